// File: doc/BRIEF.md
# Target Reset Pulse Controller

This block drives the reset line of a target board for a host that is bringing up new hardware. The line is open-drain and active-low. The block only decides when the line is pulled to ground. The host sends one 3-bit command per valid cycle. The command either latches reset on, starts a repeating reset pulse train, fires a single short pulse, or releases the line. Two further commands step the rate of the pulse train, so the start-up behaviour of the target can be watched on a scope at several speeds.

The train period is `BASE_PERIOD << (RATE_STEPS-1-idx)` clock cycles, where `idx` is a saturating rate index; a higher index gives a faster train. Every pulse, whether it belongs to the train or is a single shot, lasts `PULSE_W` cycles. An indicator output is lit whenever the line is pulled low. When the host stops sending commands, the last state is kept.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears: from the next cycle `tgt_rst_pull` is 0, the train is off and the rate index is 0, which selects the slowest period `BASE_PERIOD << (RATE_STEPS-1)`.
- R2: Command code 1 (hold) pulls the line from the next cycle on and keeps it pulled until another mode command arrives. It also stops any running train.
- R3: Command code 2 (train) stops hold and restarts the train. Starting in the cycle after the command, the line is pulled for `PULSE_W` cycles at the start of every period of `BASE_PERIOD << (RATE_STEPS-1-idx)` cycles.
- R4: Code 4 raises the rate index by one and code 3 lowers it by one. The index stays at 0 or at `RATE_STEPS-1` rather than wrapping. Neither code changes the mode.
- R5: Command code 5 (release) clears hold, the train and any single pulse in progress. The line is free from the next cycle.
- R6: Codes 0, 6 and 7 fire one pulse of exactly `PULSE_W` cycles starting in the next cycle. They turn off both the train and hold.
- R7: A pulse command that arrives while a single pulse is still running restarts the full `PULSE_W` width from the cycle after it.
- R8: `led_on` equals `tgt_rst_pull` in every cycle.
- R9: With `cmd_valid` low, the hold state, train mode and rate index keep their values for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command code (see R2 to R6) |
| tgt_rst_pull | output | 1 | 1 = drive the open-drain reset line to ground, 0 = high impedance |
| led_on | output | 1 | Indicator, lit while reset is active |

## Verification
The assertions assume that `cmd_code` is read only in cycles where `cmd_valid` is high, and that each valid cycle carries exactly one command. They also assume that `rst_n` is low at the first clock edge. The bench respects these assumptions. It drives reset low from time zero. It changes the command inputs only at falling edges and leaves `cmd_valid` high for one rising edge per command, so no command is repeated and none is ever half-seen. Train timing is checked at the periods that the chosen rate index predicts. Saturation is provoked by stepping past both ends of the index range.

// File: rtl/rstc_pkg.sv
// Package: command codes and decoded command flags shared by the reset
// pulse controller. Assumes a 3-bit command code.
package rstc_pkg;

    localparam logic [2:0] CMD_HOLD    = 3'd1;
    localparam logic [2:0] CMD_TRAIN   = 3'd2;
    localparam logic [2:0] CMD_SLOWER  = 3'd3;
    localparam logic [2:0] CMD_FASTER  = 3'd4;
    localparam logic [2:0] CMD_RELEASE = 3'd5;

    typedef struct packed {
        logic hold_set;
        logic train_set;
        logic slower;
        logic faster;
        logic release_all;
        logic shot;
    } rstc_dec_t;

    // Turn one command into one-hot action flags (all zero when not valid).
    function automatic rstc_dec_t rstc_decode(input logic valid, input logic [2:0] code);
        rstc_dec_t d;
        d = '0;
        if (valid) begin
            case (code)
                CMD_HOLD:    d.hold_set    = 1'b1;
                CMD_TRAIN:   d.train_set   = 1'b1;
                CMD_SLOWER:  d.slower      = 1'b1;
                CMD_FASTER:  d.faster      = 1'b1;
                CMD_RELEASE: d.release_all = 1'b1;
                default:     d.shot        = 1'b1;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/rstc_mode.sv
// Mode register: keeps the latched-reset and pulse-train flags.
// Assumes the decoded flags are one-hot or all zero.
module rstc_mode (
    input  logic                clk,
    input  logic                rst_n,
    input  rstc_pkg::rstc_dec_t dec,
    output logic                hold_on,
    output logic                train_on
);

    // Update the mode flags from the mode-changing commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_on  <= 1'b0;
            train_on <= 1'b0;
        end else if (dec.hold_set) begin
            hold_on  <= 1'b1;
            train_on <= 1'b0;
        end else if (dec.train_set) begin
            hold_on  <= 1'b0;
            train_on <= 1'b1;
        end else if (dec.release_all || dec.shot) begin
            hold_on  <= 1'b0;
            train_on <= 1'b0;
        end
    end

endmodule

// File: rtl/rstc_rate.sv
// Rate index: a saturating up/down counter that selects the train period.
// Assumes that faster and slower are never high together.
module rstc_rate #(
    parameter int IDX_W   = 2,
    parameter int IDX_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             faster,
    input  logic             slower,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] TOP = IDX_W'(IDX_MAX);

    // Step the index, holding it at either end of its range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (faster && idx != TOP)
            idx <= idx + 1'b1;
        else if (slower && idx != '0)
            idx <= idx - 1'b1;
    end

endmodule

// File: rtl/rstc_train.sv
// Pulse train generator: a phase counter that wraps at the selected period.
// The output is active for the first PULSE_W phases of each period.
// Assumes BASE_PERIOD > PULSE_W.
module rstc_train #(
    parameter int PULSE_W     = 4,
    parameter int BASE_PERIOD = 16,
    parameter int IDX_W       = 2,
    parameter int IDX_MAX     = 3,
    parameter int PH_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [IDX_W-1:0] idx,
    output logic             active
);

    localparam logic [PH_W-1:0]  BASE_V = PH_W'(BASE_PERIOD);
    localparam logic [PH_W-1:0]  WIDTH_V = PH_W'(PULSE_W);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(IDX_MAX);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] period_m1;

    // Last phase of the current period; a lower index gives a longer period.
    assign period_m1 = (BASE_V << (TOP - idx)) - PH_W'(1);

    // Advance the phase, wrap it at the end of the period, clear it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || restart)
            phase <= '0;
        else if (phase >= period_m1)
            phase <= '0;
        else
            phase <= phase + PH_W'(1);
    end

    assign active = enable && (phase < WIDTH_V);

endmodule

// File: rtl/rstc_shot.sv
// One-shot: counts down PULSE_W cycles after a fire request. A new fire
// reloads the count; kill clears it.
module rstc_shot #(
    parameter int PULSE_W = 4,
    parameter int SHOT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              kill,
    output logic [SHOT_W-1:0] left,
    output logic              active
);

    // Load, count down or clear the remaining pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n || kill)
            left <= '0;
        else if (fire)
            left <= SHOT_W'(PULSE_W);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign active = (left != '0);

endmodule

// File: rtl/rst_pulse_ctrl.sv
// Target reset pulse controller, top level. Decodes host commands and
// combines the latched hold, the periodic train and the one-shot into one
// pull-low request for an open-drain reset line, mirrored on an indicator.
// Assumes RATE_STEPS >= 2, PULSE_W >= 1 and BASE_PERIOD > PULSE_W.
module rst_pulse_ctrl #(
    parameter int PULSE_W     = 4,
    parameter int BASE_PERIOD = 16,
    parameter int RATE_STEPS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       tgt_rst_pull,
    output logic       led_on
);

    localparam int IDX_W      = $clog2(RATE_STEPS);
    localparam int IDX_MAX    = RATE_STEPS - 1;
    localparam int PERIOD_MAX = BASE_PERIOD << IDX_MAX;
    localparam int PH_W       = $clog2(PERIOD_MAX + 1);
    localparam int SHOT_W     = $clog2(PULSE_W + 1);

    rstc_pkg::rstc_dec_t dec;
    logic                hold_on;
    logic                train_on;
    logic [IDX_W-1:0]    rate_idx;
    logic                train_act;
    logic [SHOT_W-1:0]   shot_left;
    logic                shot_act;

    // Split the command into action flags.
    always_comb dec = rstc_pkg::rstc_decode(cmd_valid, cmd_code);

    rstc_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .hold_on  (hold_on),
        .train_on (train_on)
    );

    rstc_rate #(.IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .faster (dec.faster),
        .slower (dec.slower),
        .idx    (rate_idx)
    );

    rstc_train #(
        .PULSE_W(PULSE_W), .BASE_PERIOD(BASE_PERIOD),
        .IDX_W(IDX_W), .IDX_MAX(IDX_MAX), .PH_W(PH_W)
    ) u_train (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (train_on),
        .restart (dec.train_set),
        .idx     (rate_idx),
        .active  (train_act)
    );

    rstc_shot #(.PULSE_W(PULSE_W), .SHOT_W(SHOT_W)) u_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (dec.shot),
        .kill   (dec.release_all),
        .left   (shot_left),
        .active (shot_act)
    );

    // Reset is active if any of the three sources requests it.
    assign tgt_rst_pull = hold_on | train_act | shot_act;
    assign led_on       = tgt_rst_pull;

endmodule

// File: rtl/rst_pulse_ctrl_chk.sv
// Checker for the reset pulse controller, bound into the top module.
// Assumes rst_n is low at the first clock edge.
module rst_pulse_ctrl_chk #(
    parameter int IDX_W   = 2,
    parameter int IDX_MAX = 3,
    parameter int SHOT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic              tgt_rst_pull,
    input logic              led_on,
    input logic [IDX_W-1:0]  rate_idx,
    input logic              train_on,
    input logic [SHOT_W-1:0] shot_left
);
    import rstc_pkg::*;

    logic is_shot;
    assign is_shot = cmd_valid && (cmd_code == 3'd0 || cmd_code == 3'd6 || cmd_code == 3'd7);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!tgt_rst_pull && rate_idx == '0 && !train_on));

    p_hold_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_HOLD) |=> (tgt_rst_pull && !train_on));

    p_train_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_TRAIN) |=> (tgt_rst_pull && train_on));

    p_rate_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_FASTER && rate_idx == IDX_W'(IDX_MAX)) |=> rate_idx == IDX_W'(IDX_MAX));

    p_rate_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_SLOWER && rate_idx == '0) |=> rate_idx == '0);

    p_release_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_RELEASE) |=> !tgt_rst_pull);

    p_shot_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_shot |=> (tgt_rst_pull && !train_on && shot_left != '0));

    // R8: the indicator follows the line in every cycle
    always_comb begin
        if (rst_n) p_led_mirror_r8: assert (led_on == tgt_rst_pull);
    end

    p_idle_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(rate_idx));

    p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !train_on && shot_left == '0) |=> $stable(tgt_rst_pull));

endmodule

bind rst_pulse_ctrl rst_pulse_ctrl_chk #(
    .IDX_W(IDX_W), .IDX_MAX(IDX_MAX), .SHOT_W(SHOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .tgt_rst_pull (tgt_rst_pull),
    .led_on       (led_on),
    .rate_idx     (rate_idx),
    .train_on     (train_on),
    .shot_left    (shot_left)
);

// File: tb/rst_pulse_ctrl_test.sv
module rst_pulse_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 4;
    localparam int BASE = 16;
    localparam int STEPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       tgt_rst_pull;
    logic       led_on;

    int checks = 0;
    int errors = 0;

    rst_pulse_ctrl #(.PULSE_W(PW), .BASE_PERIOD(BASE), .RATE_STEPS(STEPS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tgt_rst_pull(tgt_rst_pull), .led_on(led_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       v;
        logic [2:0] c;
        logic       e;
    } vec_t;

    // One entry per clock: command presented, expected line state after it.
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 1'b0},  // idle after reset
        '{1'b1, 3'd1, 1'b1},  // hold
        '{1'b0, 3'd0, 1'b1},
        '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd5, 1'b0},  // release
        '{1'b0, 3'd0, 1'b0},
        '{1'b1, 3'd1, 1'b1},  // hold again
        '{1'b1, 3'd0, 1'b1},  // shot, sample 1
        '{1'b0, 3'd0, 1'b1},
        '{1'b0, 3'd0, 1'b1},
        '{1'b0, 3'd0, 1'b1},  // sample 4
        '{1'b0, 3'd0, 1'b0},  // shot over, hold was cancelled
        '{1'b1, 3'd6, 1'b1},  // shot, sample 1
        '{1'b0, 3'd0, 1'b1},
        '{1'b1, 3'd7, 1'b1},  // retrigger, sample 1 again
        '{1'b0, 3'd0, 1'b1},
        '{1'b0, 3'd0, 1'b1},
        '{1'b0, 3'd0, 1'b1},  // sample 4 of the retriggered pulse
        '{1'b0, 3'd0, 1'b0}
    };

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // Present a command for one rising edge; return at the following falling edge.
    task automatic step(input logic v, input logic [2:0] c);
        cmd_valid = v;
        cmd_code  = c;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
    endtask

    // Count the cycles in a window of idle clocks where the line differs from want.
    task automatic idle_expect(input int n, input logic want, input string req);
        int bad = 0;
        for (int t = 0; t < n; t++) begin
            step(1'b0, 3'd0);
            if (tgt_rst_pull !== want) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: got %0d mismatching cycles expected 0", req, bad);
        end
    endtask

    // After a train command: check phases 1..period (pulse at 0..PW-1 and at period).
    task automatic check_train(input int period, input string req);
        int bad = 0;
        for (int t = 1; t <= period; t++) begin
            step(1'b0, 3'd0);
            if (tgt_rst_pull !== ((t < PW) || (t == period))) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s period %0d: got %0d mismatching cycles expected 0", req, period, bad);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 line after reset", tgt_rst_pull, 1'b0);
        check("R8 led after reset", led_on, 1'b0);
        rst_n = 1'b1;

        // Table walk: hold, release, shot cancels hold, retrigger (R2 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].v, VECS[i].c);
            check($sformatf("R2/R5/R6/R7 vector %0d", i), tgt_rst_pull, VECS[i].e);
            check($sformatf("R8 vector %0d", i), led_on, tgt_rst_pull);
        end

        // R3 and R1: slowest period after reset
        step(1'b1, 3'd2);
        check("R3 train first cycle", tgt_rst_pull, 1'b1);
        check_train(BASE << (STEPS-1), "R3 slowest train");

        // R4: slower at index 0 saturates, train keeps running
        step(1'b1, 3'd3);
        step(1'b1, 3'd2);
        check_train(BASE << (STEPS-1), "R4 bottom saturation");

        // R4: five steps up saturate at the fastest rate
        for (int k = 0; k < 5; k++) step(1'b1, 3'd4);
        step(1'b1, 3'd2);
        check_train(BASE, "R4 top saturation");

        // R4: one step down doubles the period
        step(1'b1, 3'd3);
        step(1'b1, 3'd2);
        check_train(BASE * 2, "R4 single step down");

        // R6: a shot during the train stops it
        step(1'b1, 3'd6);
        idle_expect(PW - 1, 1'b1, "R6 shot width in train");
        idle_expect(100, 1'b0, "R6 train cancelled by shot");

        // R2: hold during the train stops it and stays pulled
        step(1'b1, 3'd2);
        idle_expect(0, 1'b1, "R3 restart");
        for (int k = 0; k < 6; k++) step(1'b0, 3'd0);
        step(1'b1, 3'd1);
        idle_expect(80, 1'b1, "R2 hold cancels train");

        // R5: release stops the train and an active shot
        step(1'b1, 3'd2);
        step(1'b1, 3'd5);
        check("R5 release during train", tgt_rst_pull, 1'b0);
        idle_expect(80, 1'b0, "R5 train stays off");
        step(1'b1, 3'd0);
        step(1'b1, 3'd5);
        check("R5 release cuts shot", tgt_rst_pull, 1'b0);

        // R9: idle host keeps the hold
        step(1'b1, 3'd1);
        idle_expect(300, 1'b1, "R9 hold retained");
        step(1'b1, 3'd5);
        idle_expect(50, 1'b0, "R9 release retained");

        // R1: reset during hold frees the line and returns to the slowest rate
        step(1'b1, 3'd1);
        rst_n = 1'b0;
        step(1'b0, 3'd0);
        check("R1 reset during hold", tgt_rst_pull, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 3'd2);
        check_train(BASE << (STEPS-1), "R1 rate index cleared");

        finish_run();
    end

endmodule